// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block forms a 20-bit physical memory address from a 16-bit segment value and a 16-bit effective address. The effective address is built from base, index and displacement operands according to a mode select: a plain constant, a register alone, base plus index, register plus constant, base plus index plus constant, or a register plus a second register scaled by 1, 2, 4 or 8. The segment value is read from an internal file of six segment registers: code, stack and four data segments. The selected value is shifted left by four bits and added to the effective address. Segments therefore start on 16-byte boundaries, and each covers 64 KB.

The segment is picked by a default rule. If the address is based on a stack-pointer or frame-pointer register, the stack segment is used. Otherwise the primary data segment is used. An override input with its own valid bit can replace this choice. The caller supplies the operand values and a flag that marks a stack-type base register. The general-purpose register file, instruction decode and the memory interface sit outside this block. A one-cycle request strobe starts the computation. The result and a valid strobe appear on registered outputs at the next clock edge.

Top module: `seg_addr_gen`

## Requirements
- R1: A request sampled at a rising edge drives `pa` to ((segment << 4) + EA) modulo 2^20 from that edge. `pa_valid` is high for exactly the cycle after each request cycle.
- R2: Mode codes form the 16-bit effective address as follows: 0 gives disp, 1 gives base, 2 gives base+index, 3 gives base+disp, 4 gives base+index+disp, and 5 gives base+(index*scale). Each sum is truncated to 16 bits.
- R3: In mode 5, scale code 0, 1, 2 or 3 multiplies index by 1, 2, 4 or 8.
- R4: The reserved mode codes 6 and 7 form the effective address as disp, the same as mode 0.
- R5: With no active override, modes 1 to 5 use segment SS when `base_is_stack` is high and DS when it is low. Modes 0, 6 and 7 always use DS.
- R6: When `ovr_valid` is high and `ovr_sel` is 0 to 5, the segment named by `ovr_sel` replaces the default. If `ovr_sel` is 6 or 7, or `ovr_valid` is low, the default applies.
- R7: Segment select codes are 0 CS, 1 SS, 2 DS, 3 ES, 4 FS and 5 GS. A write with `wr_en` high stores `wr_data` at the rising edge. A request in the same cycle as the write uses the old value, and a request in a later cycle uses the new value.
- R8: A write with `wr_sel` 6 or 7 changes no segment register.
- R9: Synchronous active-low reset clears all six segment registers, `pa` and `pa_valid` to zero.
- R10: In a cycle with no request, `pa` keeps its previous value.
- R11: A carry out of bit 19 of the physical sum is dropped. For example, segment FFFFh with EA FFFFh gives 0FFEFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 3 | Segment register to write (0 CS to 5 GS) |
| wr_data | input | 16 | Value to write |
| req | input | 1 | Address request strobe |
| mode | input | 3 | Effective address mode code |
| base_is_stack | input | 1 | Base register is a stack or frame pointer |
| base | input | 16 | Base register value |
| index | input | 16 | Index register value |
| disp | input | 16 | Displacement constant |
| scale | input | 2 | Index scale code (1, 2, 4, 8) |
| ovr_valid | input | 1 | Segment override active |
| ovr_sel | input | 3 | Override segment code |
| pa | output | 20 | Registered physical address |
| pa_valid | output | 1 | Physical address valid strobe |

## Verification
The bench builds the block with its default parameters: 16-bit segments and effective addresses, a 4-bit shift, and six segment registers. These sizes keep the mode, select and scale fields small enough to sweep completely. It runs every combination of the eight mode codes, both stack flags, all eight override codes plus a disabled override, and all four scale codes, each over operand sets chosen to overflow 16 bits and, with segment FFFFh, to carry out of bit 19. Separate sequences cover a write in the same cycle as a request, writes to the unused codes, and the cleared state after reset.

// File: rtl/seg_addr_pkg.sv
// Shared widths and code values of the segmented address generator.
// Assumes the mode and segment code widths below are fixed by the callers.
package seg_addr_pkg;
    localparam int MODE_W = 3;
    localparam int SEL_W  = 3;
    localparam int SCL_W  = 2;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [SEL_W-1:0]  sel_t;

    localparam mode_t MODE_CONST     = 3'd0;
    localparam mode_t MODE_REG       = 3'd1;
    localparam mode_t MODE_BASE_IDX  = 3'd2;
    localparam mode_t MODE_REG_DISP  = 3'd3;
    localparam mode_t MODE_BIDX_DISP = 3'd4;
    localparam mode_t MODE_SCALED    = 3'd5;

    localparam sel_t SEL_CODE  = 3'd0;
    localparam sel_t SEL_STACK = 3'd1;
    localparam sel_t SEL_DATA0 = 3'd2;
    localparam sel_t SEL_DATA1 = 3'd3;
    localparam sel_t SEL_DATA2 = 3'd4;
    localparam sel_t SEL_DATA3 = 3'd5;
endpackage

// File: rtl/seg_regfile.sv
// Segment register file: NUM_SEG entries, one write port and one
// combinational read port. Writes to codes at or above NUM_SEG are dropped.
// Reads return the value stored before any write in the same cycle.
module seg_regfile
    import seg_addr_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int SEG_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  sel_t             wr_sel,
    input  logic [SEG_W-1:0] wr_data,
    input  sel_t             rd_sel,
    output logic [SEG_W-1:0] rd_data
);
    localparam sel_t LAST_SEL = SEL_W'(NUM_SEG - 1);

    logic [NUM_SEG-1:0][SEG_W-1:0] regs;

    genvar g;
    generate
        for (g = 0; g < NUM_SEG; g++) begin : g_entry
            // Store one segment register; reset clears it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= '0;
                else if (wr_en && wr_sel == SEL_W'(g))
                    regs[g] <= wr_data;
            end
        end
    endgenerate

    // Read the selected entry; unused codes read as zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_SEG; k++)
            if (rd_sel == SEL_W'(k))
                rd_data = regs[k];
    end

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel <= LAST_SEL) |=> regs[$past(wr_sel)] == $past(wr_data));

    assert_bad_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel > LAST_SEL) |=> $stable(regs));

    assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));
endmodule

// File: rtl/ea_calc.sv
// Effective address former: combines base, index and displacement as the
// mode code selects. All sums wrap at EA_W bits. Reserved codes act as
// the constant-only mode.
module ea_calc
    import seg_addr_pkg::*;
#(
    parameter int EA_W = 16
) (
    input  mode_t            mode,
    input  logic [EA_W-1:0]  base,
    input  logic [EA_W-1:0]  index,
    input  logic [EA_W-1:0]  disp,
    input  logic [SCL_W-1:0] scale,
    output logic [EA_W-1:0]  ea
);
    logic [EA_W-1:0] scaled_idx;
    logic [EA_W-1:0] base_idx;

    // Scale the index by a power of two and form the shared base+index term.
    always_comb begin
        scaled_idx = index << scale;
        base_idx   = base + index;
    end

    // Pick the effective address for the requested mode.
    always_comb begin
        case (mode)
            MODE_REG:       ea = base;
            MODE_BASE_IDX:  ea = base_idx;
            MODE_REG_DISP:  ea = base + disp;
            MODE_BIDX_DISP: ea = base_idx + disp;
            MODE_SCALED:    ea = base + scaled_idx;
            default:        ea = disp;
        endcase
    end
endmodule

// File: rtl/seg_select.sv
// Segment chooser: applies the stack-or-data default rule and the
// override. Assumes base_is_stack is meaningful only when the mode has a
// base register.
module seg_select
    import seg_addr_pkg::*;
#(
    parameter int NUM_SEG = 6
) (
    input  mode_t mode,
    input  logic  base_is_stack,
    input  logic  ovr_valid,
    input  sel_t  ovr_sel,
    output sel_t  seg_sel
);
    localparam sel_t LAST_SEL = SEL_W'(NUM_SEG - 1);

    logic has_base;
    sel_t dflt_sel;

    // Decide whether the mode uses a base register.
    always_comb begin
        case (mode)
            MODE_REG, MODE_BASE_IDX, MODE_REG_DISP,
            MODE_BIDX_DISP, MODE_SCALED: has_base = 1'b1;
            default:                     has_base = 1'b0;
        endcase
    end

    // Default segment, then a valid override on top of it.
    always_comb begin
        dflt_sel = (has_base && base_is_stack) ? SEL_STACK : SEL_DATA0;
        if (ovr_valid && ovr_sel <= LAST_SEL)
            seg_sel = ovr_sel;
        else
            seg_sel = dflt_sel;
    end
endmodule

// File: rtl/seg_addr_gen.sv
// Segmented physical address generator top. Reads the chosen segment,
// forms the effective address and registers (segment << SHIFT) + EA,
// dropping any carry out of the top bit. Assumes EA_W < SEG_W + SHIFT.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int NUM_SEG = 6,
    parameter int SEG_W   = 16,
    parameter int EA_W    = 16,
    parameter int SHIFT   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_sel,
    input  logic [15:0]  wr_data,
    input  logic         req,
    input  logic [2:0]   mode,
    input  logic         base_is_stack,
    input  logic [15:0]  base,
    input  logic [15:0]  index,
    input  logic [15:0]  disp,
    input  logic [1:0]   scale,
    input  logic         ovr_valid,
    input  logic [2:0]   ovr_sel,
    output logic [19:0]  pa,
    output logic         pa_valid
);
    localparam int   PA_W     = SEG_W + SHIFT;
    localparam sel_t LAST_SEL = SEL_W'(NUM_SEG - 1);

    sel_t            seg_sel;
    logic [SEG_W-1:0] seg_val;
    logic [EA_W-1:0]  ea;
    logic [PA_W-1:0]  seg_base;
    logic [PA_W-1:0]  pa_next;

    seg_regfile #(.NUM_SEG(NUM_SEG), .SEG_W(SEG_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (seg_sel),
        .rd_data (seg_val)
    );

    ea_calc #(.EA_W(EA_W)) u_ea (
        .mode  (mode),
        .base  (base),
        .index (index),
        .disp  (disp),
        .scale (scale),
        .ea    (ea)
    );

    seg_select #(.NUM_SEG(NUM_SEG)) u_sel (
        .mode          (mode),
        .base_is_stack (base_is_stack),
        .ovr_valid     (ovr_valid),
        .ovr_sel       (ovr_sel),
        .seg_sel       (seg_sel)
    );

    // Shift the segment to its 16-byte base and add the zero-extended EA.
    always_comb begin
        seg_base = {seg_val, {SHIFT{1'b0}}};
        pa_next  = seg_base + {{(PA_W-EA_W){1'b0}}, ea};
    end

    // Register the address on a request and the strobe every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa       <= '0;
            pa_valid <= 1'b0;
        end else begin
            pa_valid <= req;
            if (req)
                pa <= pa_next;
        end
    end

    assert_valid_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pa_valid);

    assert_valid_only_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !pa_valid);

    assert_low_bits_from_ea_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> pa[SHIFT-1:0] == $past(ea[SHIFT-1:0]));

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(pa));

    assert_override_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_valid && ovr_sel <= LAST_SEL) |-> seg_sel == ovr_sel);

    assert_const_mode_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_valid && (mode == MODE_CONST || mode > MODE_SCALED)) |-> seg_sel == SEL_DATA0);

    assert_stack_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_valid && base_is_stack && mode != MODE_CONST && mode <= MODE_SCALED)
        |-> seg_sel == SEL_STACK);
endmodule

// File: tb/tb_seg_addr_gen.sv
// Self-checking bench: reset state, write ordering, dropped writes, and a
// full sweep of mode, stack flag, override and scale codes over operand sets.
module tb_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        req = 1'b0;
    logic [2:0]  mode = '0;
    logic        base_is_stack = 1'b0;
    logic [15:0] base = '0;
    logic [15:0] index = '0;
    logic [15:0] disp = '0;
    logic [1:0]  scale = '0;
    logic        ovr_valid = 1'b0;
    logic [2:0]  ovr_sel = '0;
    logic [19:0] pa;
    logic        pa_valid;

    int checks = 0;
    int errors = 0;
    logic [15:0] segm [6];

    seg_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .req(req), .mode(mode),
        .base_is_stack(base_is_stack), .base(base), .index(index),
        .disp(disp), .scale(scale), .ovr_valid(ovr_valid),
        .ovr_sel(ovr_sel), .pa(pa), .pa_valid(pa_valid)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [19:0] act, input logic [19:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %05h expected %05h", tag, act, expv);
        end
    endtask

    function automatic logic [19:0] model(input logic [2:0] m, input logic stk,
            input logic ov, input logic [2:0] os, input logic [1:0] sc,
            input logic [15:0] b, input logic [15:0] i, input logic [15:0] d);
        logic [15:0] ea;
        logic [2:0]  s;
        logic [19:0] sum;
        case (m)
            3'd1: ea = b;
            3'd2: ea = b + i;
            3'd3: ea = b + d;
            3'd4: ea = b + i + d;
            3'd5: ea = b + 16'(i << sc);
            default: ea = d;
        endcase
        if (ov && os <= 3'd5) s = os;
        else if (m >= 3'd1 && m <= 3'd5 && stk) s = 3'd1;
        else s = 3'd2;
        sum = {segm[s], 4'h0} + {4'h0, ea};
        return sum;
    endfunction

    task automatic do_req(input string tag, input logic [2:0] m, input logic stk,
            input logic ov, input logic [2:0] os, input logic [1:0] sc,
            input logic [15:0] b, input logic [15:0] i, input logic [15:0] d);
        logic [19:0] e;
        e = model(m, stk, ov, os, sc, b, i, d);
        @(negedge clk);
        req = 1'b1; mode = m; base_is_stack = stk; ovr_valid = ov; ovr_sel = os;
        scale = sc; base = b; index = i; disp = d;
        @(posedge clk); #1;
        check({tag, " R1 pa"}, pa, e);
        check({tag, " R1 pa_valid"}, {19'h0, pa_valid}, 20'h1);
        @(negedge clk);
        req = 1'b0; base = ~b; disp = ~d; mode = 3'd1;
        @(posedge clk); #1;
        check("R10 hold pa", pa, e);
        check("R1 pa_valid drop", {19'h0, pa_valid}, 20'h0);
    endtask

    task automatic seg_write(input logic [2:0] s, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = v;
        @(posedge clk); #1;
        @(negedge clk);
        wr_en = 1'b0;
        if (s <= 3'd5) segm[s] = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] ob [4];
        logic [15:0] oi [4];
        logic [15:0] od [4];
        ob[0] = 16'h0100; oi[0] = 16'h0010; od[0] = 16'h0005;
        ob[1] = 16'hFFFF; oi[1] = 16'hFFFF; od[1] = 16'h0002;
        ob[2] = 16'h8000; oi[2] = 16'h4001; od[2] = 16'hC000;
        ob[3] = 16'h1234; oi[3] = 16'h00FF; od[3] = 16'hFFF0;
        for (int k = 0; k < 6; k++) segm[k] = 16'h0;

        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R9 pa reset", pa, 20'h0);
        check("R9 pa_valid reset", {19'h0, pa_valid}, 20'h0);
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < 6; k++)
            do_req("R9 cleared segment", 3'd0, 1'b0, 1'b1, 3'(k), 2'd0, 16'h0, 16'h0, 16'h1234);

        // R7: load all segments, then confirm each through an override
        seg_write(3'd0, 16'h1200);
        seg_write(3'd1, 16'h3000);
        seg_write(3'd2, 16'h2000);
        seg_write(3'd3, 16'h6655);
        seg_write(3'd4, 16'h8877);
        seg_write(3'd5, 16'hFFFF);
        for (int k = 0; k < 6; k++)
            do_req("R7 written segment", 3'd0, 1'b0, 1'b1, 3'(k), 2'd0, 16'h0, 16'h0, 16'h0);

        // R7: request in the same cycle as a write sees the old value
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd3; wr_data = 16'h0001;
        req = 1'b1; mode = 3'd0; ovr_valid = 1'b1; ovr_sel = 3'd3; disp = 16'h0;
        @(posedge clk); #1;
        check("R7 same-cycle old value", pa, 20'h66550);
        @(negedge clk);
        wr_en = 1'b0; req = 1'b0;
        segm[3] = 16'h0001;
        do_req("R7 next-cycle new value", 3'd0, 1'b0, 1'b1, 3'd3, 2'd0, 16'h0, 16'h0, 16'h0);

        // R8: writes to unused codes change nothing
        seg_write(3'd6, 16'hDEAD);
        seg_write(3'd7, 16'hBEEF);
        for (int k = 0; k < 6; k++)
            do_req("R8 unused write code", 3'd0, 1'b0, 1'b1, 3'(k), 2'd0, 16'h0, 16'h0, 16'h0);

        // R11: wrap at 1 MB
        do_req("R11 wrap", 3'd0, 1'b0, 1'b1, 3'd5, 2'd0, 16'h0, 16'h0, 16'hFFFF);
        check("R11 wrap literal", pa, 20'h0FFEF);

        // R2 R3 R4 R5 R6: full sweep
        for (int m = 0; m < 8; m++)
            for (int st = 0; st < 2; st++)
                for (int ov = 0; ov < 9; ov++)
                    for (int sc = 0; sc < 4; sc++)
                        for (int op = 0; op < 4; op++) begin
                            string tag;
                            if (ov < 8) tag = "R6 override";
                            else if (m >= 6) tag = "R4 reserved mode";
                            else if (m == 5) tag = "R3 scaled";
                            else if (st == 1) tag = "R5 stack default";
                            else tag = "R2 mode";
                            do_req(tag, 3'(m), st[0], ov < 8, (ov < 8) ? 3'(ov) : 3'd1,
                                   2'(sc), ob[op], oi[op], od[op]);
                        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule